// File: doc/BRIEF.md
# Receive Data-Available Flag Generator

This block produces the "data available" status seen by a link-layer device that reads from a receive interface with several ports, each with its own FIFO. Every clock it looks at each port's FIFO fill level, its count of complete cells and whether an end-of-packet is waiting. It compares these against a shared almost-empty threshold and keeps one availability bit per port. The rules for setting and clearing that bit depend on the interface mode. Cell modes count whole cells and keep the bit between the set and clear points, which gives hysteresis. Packet modes also set the bit when an end-of-packet is waiting.

The block drives two kinds of output. The first is a flag for the port the link layer is polling, together with an output enable that an external pad uses to tri-state the shared line. The second is one direct flag per port. The poll address is registered on the clock edge, and the polled flag shows that port's state from the same edge. Every pin is a plain control or status signal. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rx_avail_flags`

## Requirements
- R1: While `rst_n` is low, `polled_avail`, `polled_oe` and every bit of `direct_avail` are 0.
- R2: In a cell mode (`mode` 0 = cell level 2, 1 = cell level 3), a port's state bit is 1 after any edge at which its cell count is strictly greater than `ae_thresh`. A count equal to the threshold does not set it.
- R3: In a cell mode, a port's state bit is 0 after an edge at which its cell count is 0. When the count is between 1 and `ae_thresh`, the bit keeps its previous value.
- R4: In a packet mode (`mode` 2 = packet level 2, 3 = packet level 3), a port's state bit is 1 after an edge at which its fill level is greater than `ae_thresh` or its `eop_rdy` bit is 1.
- R5: In a packet mode, a port's state bit is 0 after an edge at which its `eop_rdy` bit is 0 and its fill level is at or below `ae_thresh`.
- R6: `polled_avail` equals the state bit of the port whose address was on `poll_addr` at the last edge, provided `poll_vld` was 1 at that edge and the address was below `NPORTS`. Otherwise it is 0.
- R7: In level-2 modes (`mode` 0 or 2), `polled_oe` is 1 only after an edge at which the poll was valid and in range and `dp_rst` was 0.
- R8: In level-3 modes (`mode` 1 or 3), `polled_oe` is 1 after every edge once reset is released.
- R9: `direct_avail[i]` equals port i's state bit, except that all direct flags are 0 after an edge at which `mode` was 3 or `poll_status_only` was 1.
- R10: An edge with `dp_rst` high clears every port's state bit, so all flags read 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_rst | input | 1 | Synchronous data path reset |
| mode | input | 2 | 0 cell L2, 1 cell L3, 2 packet L2, 3 packet L3 |
| poll_status_only | input | 1 | Polled-status mode; forces direct flags low |
| ae_thresh | input | LVL_W | Almost-empty threshold shared by all ports |
| fill_lvl | input | NPORTS*LVL_W | Per-port FIFO fill level, port i at [i*LVL_W +: LVL_W] |
| cell_cnt | input | NPORTS*LVL_W | Per-port complete cell count, same packing |
| eop_rdy | input | NPORTS | Per-port end-of-packet waiting |
| poll_vld | input | 1 | A poll is being issued this cycle |
| poll_addr | input | ADDR_W | Polled port address |
| polled_avail | output | 1 | Availability of the polled port |
| polled_oe | output | 1 | Drive enable for the polled flag |
| direct_avail | output | NPORTS | Per-port direct availability |

## Verification
The cell rules are driven with counts above, at and below the threshold, and then down to zero. This separates the strict comparison and the clear-on-empty point from the hold band in between. The packet rules are exercised with a fill level above the threshold, a fill level at the threshold, and an end-of-packet with an empty FIFO, which shows that either condition alone sets the flag. Polls to valid, out-of-range and idle addresses in level-2 and level-3 modes separate the drive-enable rules. After that, a long run of random modes, levels, polls and data path resets is compared cycle by cycle against a behavioural model.

// File: rtl/rxav_pkg.sv
package rxav_pkg;
  typedef enum logic [1:0] {
    MODE_CELL_L2 = 2'd0,
    MODE_CELL_L3 = 2'd1,
    MODE_PKT_L2  = 2'd2,
    MODE_PKT_L3  = 2'd3
  } rx_mode_e;

  function automatic logic mode_is_pkt(input rx_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_l3(input rx_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/rxav_port_flag.sv
module rxav_port_flag #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_rst,
  input  logic             pkt_mode,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] fill,
  input  logic [LVL_W-1:0] cells,
  input  logic             eop,
  output logic             flag
);
  logic set_c, clr_c;

  always_comb begin
    if (pkt_mode) begin
      set_c = (fill > thresh) || eop;
      clr_c = !eop && (fill <= thresh);
    end else begin
      set_c = cells > thresh;
      clr_c = cells == '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (dp_rst) flag <= 1'b0;
    else if (set_c)  flag <= 1'b1;
    else if (clr_c)  flag <= 1'b0;
  end

  // R2: more cells than the threshold sets the flag
  a_r2_cell_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_mode && !dp_rst && cells > thresh) |=> flag);
  // R3: an empty port clears; the band in between holds
  a_r3_cell_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_mode && cells == '0) |=> !flag);
  a_r3_cell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_mode && !dp_rst && cells != '0 && cells <= thresh) |=> (flag == $past(flag)));
  // R4: a waiting end-of-packet sets in packet mode
  a_r4_eop_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_mode && !dp_rst && eop) |=> flag);
  // R5: no end-of-packet and at or below threshold clears
  a_r5_pkt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_mode && !eop && fill <= thresh) |=> !flag);
endmodule

// File: rtl/rxav_poll_track.sv
module rxav_poll_track #(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_rst,
  input  logic              level3,
  input  logic              poll_vld,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [NPORTS-1:0] port_flags,
  output logic              polled_avail,
  output logic              polled_oe
);
  logic [ADDR_W-1:0] addr_q;
  logic              ok_q, oe_q;
  logic              in_range, ok_d;

  assign in_range = 32'(poll_addr) < NPORTS;
  assign ok_d     = poll_vld && in_range && !dp_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ok_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      addr_q <= poll_addr;
      ok_q   <= ok_d;
      oe_q   <= level3 ? 1'b1 : ok_d;
    end
  end

  always_comb begin
    polled_avail = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      if (ok_q && addr_q == ADDR_W'(i)) polled_avail = port_flags[i];
  end

  assign polled_oe = oe_q;

  // R6: an out-of-range poll reads as not polled
  a_r6_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld && !in_range) |=> !polled_avail);
  // R7: level-2 modes release the line when nothing is polled
  a_r7_l2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!level3 && (!poll_vld || dp_rst)) |=> !polled_oe);
  // R8: level-3 modes always drive
  a_r8_l3_drive: assert property (@(posedge clk) disable iff (!rst_n)
    level3 |=> polled_oe);
endmodule

// File: rtl/rx_avail_flags.sv
module rx_avail_flags #(
  parameter int NPORTS = 4,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dp_rst,
  input  logic [1:0]               mode,
  input  logic                     poll_status_only,
  input  logic [LVL_W-1:0]         ae_thresh,
  input  logic [NPORTS*LVL_W-1:0]  fill_lvl,
  input  logic [NPORTS*LVL_W-1:0]  cell_cnt,
  input  logic [NPORTS-1:0]        eop_rdy,
  input  logic                     poll_vld,
  input  logic [ADDR_W-1:0]        poll_addr,
  output logic                     polled_avail,
  output logic                     polled_oe,
  output logic [NPORTS-1:0]        direct_avail
);
  import rxav_pkg::*;

  rx_mode_e          mode_e;
  logic [NPORTS-1:0] port_st;
  logic              dir_en_q;

  assign mode_e = rx_mode_e'(mode);

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    rxav_port_flag #(.LVL_W(LVL_W)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .dp_rst   (dp_rst),
      .pkt_mode (mode_is_pkt(mode_e)),
      .thresh   (ae_thresh),
      .fill     (fill_lvl[g*LVL_W +: LVL_W]),
      .cells    (cell_cnt[g*LVL_W +: LVL_W]),
      .eop      (eop_rdy[g]),
      .flag     (port_st[g])
    );
  end

  rxav_poll_track #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_poll (
    .clk          (clk),
    .rst_n        (rst_n),
    .dp_rst       (dp_rst),
    .level3       (mode_is_l3(mode_e)),
    .poll_vld     (poll_vld),
    .poll_addr    (poll_addr),
    .port_flags   (port_st),
    .polled_avail (polled_avail),
    .polled_oe    (polled_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_en_q <= 1'b0;
    else        dir_en_q <= (mode_e != MODE_PKT_L3) && !poll_status_only;
  end

  assign direct_avail = dir_en_q ? port_st : '0;

  // R9: direct flags silenced in packet level 3 and polled-status mode
  a_r9_dir_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 || poll_status_only) |=> (direct_avail == '0));
  // R10: data path reset empties every flag
  a_r10_dp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |=> (direct_avail == '0 && !polled_avail));
  // R1: nothing asserted during reset
  always_comb if (!rst_n) a_r1_reset_low: assert (!polled_oe && direct_avail == '0);
endmodule

// File: tb/tb_rx_avail_flags.sv
module tb_rx_avail_flags;
  localparam int NP = 4, LW = 8, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, dp_rst = 1'b0, pso = 1'b0, poll_vld = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [LW-1:0] thr = 8'd2;
  logic [NP*LW-1:0] fill_v = '0, cnt_v = '0;
  logic [NP-1:0] eop = '0;
  logic [AW-1:0] addr = '0;
  logic polled_avail, polled_oe;
  logic [NP-1:0] direct_avail;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  rx_avail_flags #(.NPORTS(NP), .LVL_W(LW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .dp_rst(dp_rst), .mode(mode), .poll_status_only(pso),
    .ae_thresh(thr), .fill_lvl(fill_v), .cell_cnt(cnt_v), .eop_rdy(eop),
    .poll_vld(poll_vld), .poll_addr(addr), .polled_avail(polled_avail),
    .polled_oe(polled_oe), .direct_avail(direct_avail));

  // behavioural reference
  bit m_st[NP];
  bit m_mask, m_ok, m_oe;
  int m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_st[i]) m_st[i] = 0;
      m_mask = 0; m_ok = 0; m_oe = 0; m_addr = 0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        int f, c;
        f = fill_v[i*LW +: LW];
        c = cnt_v[i*LW +: LW];
        if (dp_rst) m_st[i] = 0;
        else if (mode[1]) m_st[i] = (f > thr) || eop[i];
        else if (c > thr) m_st[i] = 1;
        else if (c == 0) m_st[i] = 0;
      end
      m_mask = (mode != 2'd3) && !pso;
      m_ok = poll_vld && (int'(addr) < NP) && !dp_rst;
      m_oe = mode[0] ? 1'b1 : m_ok;
      m_addr = addr;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R6 polled flag", polled_avail, m_ok ? m_st[m_addr] : 1'b0);
    chk(mode[0] ? "R8 drive enable" : "R7 drive enable", polled_oe, m_oe);
    for (int i = 0; i < NP; i++) chk("R9 direct flag", direct_avail[i], m_st[i] & m_mask);
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cnt(int p, int v); cnt_v[p*LW +: LW] = LW'(v); endtask
  task automatic set_fill(int p, int v); fill_v[p*LW +: LW] = LW'(v); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset polled", polled_avail, 1'b0);
    chk("R1 reset oe", polled_oe, 1'b0);
    chk("R1 reset direct", |direct_avail, 1'b0);
    rst_n = 1'b1;
    step();
    set_cnt(0, 3); poll_vld = 1; addr = 0; step();
    chk("R2 set above thr", direct_avail[0], 1'b1);
    chk("R6 polled port0", polled_avail, 1'b1);
    chk("R7 oe on poll", polled_oe, 1'b1);
    set_cnt(0, 1); step();
    chk("R3 hold band", direct_avail[0], 1'b1);
    set_cnt(0, 0); step();
    chk("R3 clear empty", direct_avail[0], 1'b0);
    set_cnt(0, 2); step();
    chk("R2 equal no set", direct_avail[0], 1'b0);
    set_cnt(0, 3); step();
    addr = 3'd5; step();
    chk("R6 bad addr flag", polled_avail, 1'b0);
    chk("R7 bad addr oe", polled_oe, 1'b0);
    poll_vld = 0; addr = 0; step();
    chk("R7 idle oe", polled_oe, 1'b0);
    mode = 2'd2; set_fill(1, 3); step();
    chk("R4 fill set", direct_avail[1], 1'b1);
    chk("R5 port0 clear", direct_avail[0], 1'b0);
    set_fill(1, 2); step();
    chk("R5 at thr clear", direct_avail[1], 1'b0);
    eop[1] = 1; set_fill(1, 0); step();
    chk("R4 eop set", direct_avail[1], 1'b1);
    poll_vld = 1; addr = 1; pso = 1; step();
    chk("R9 pso low", |direct_avail, 1'b0);
    chk("R6 polled port1", polled_avail, 1'b1);
    pso = 0; mode = 2'd3; poll_vld = 0; step();
    chk("R9 pkt L3 low", |direct_avail, 1'b0);
    chk("R8 L3 oe", polled_oe, 1'b1);
    mode = 2'd1; set_cnt(2, 3); step();
    chk("R8 cell L3 oe", polled_oe, 1'b1);
    chk("R2 port2 set", direct_avail[2], 1'b1);
    mode = 2'd0; dp_rst = 1; step();
    chk("R10 dp clear", |direct_avail, 1'b0);
    chk("R10 dp oe", polled_oe, 1'b0);
    dp_rst = 0; step();
    chk("R2 port2 reset", direct_avail[2], 1'b1);
    for (int n = 0; n < 600; n++) begin
      if (n % 25 == 0) mode = 2'($urandom_range(0, 3));
      pso = ($urandom_range(0, 9) == 0);
      dp_rst = ($urandom_range(0, 19) == 0);
      thr = LW'($urandom_range(0, 3));
      for (int p = 0; p < NP; p++) begin
        set_cnt(p, $urandom_range(0, 4));
        set_fill(p, $urandom_range(0, 4));
        eop[p] = ($urandom_range(0, 3) == 0);
      end
      poll_vld = $urandom_range(0, 1);
      addr = AW'($urandom_range(0, 7));
      step();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule